// File: doc/BRIEF.md
# Strobe-Idle Automatic Power-Down Controller

This block sits beside the bus of an 8-bit microcontroller and decides when the programmable logic next to it may drop into a power-down state. A free-running input clock is the time base. The address-strobe (latch-enable) line is brought into that clock domain and watched for transitions. Once the strobe has been quiet for a set number of input-clock cycles, and automatic power-down has been armed by software, the block raises its power-down output. The next strobe transition ends the power-down state.

Two 8-bit control registers can be written over a small synchronous port and read back combinationally. They arm automatic power-down, select the low-power (non-turbo) logic mode, and hold per-signal blocking masks. Each mask bit gates one microcontroller control input before it reaches the logic array. In power-down, every gated control output is forced inactive, whatever the masks hold.

Top module: `idle_pd_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00, `pd_active` is 0, `pd_enable` is 0 and `slow_mode` is 0.
- R2: When `wr_en` is high at a rising clock edge, `wr_data` is stored in register 0 when `wr_sel`=0 and in register 2 when `wr_sel`=1. `rd_data` shows register 0 when `rd_sel`=0 and register 2 when `rd_sel`=1, with no clock delay.
- R3: `pd_enable` equals bit 1 of register 0. While that bit is 0, `pd_active` is 0 one cycle later and stays 0 however long the strobe is idle.
- R4: The strobe passes through two synchronizer flops, followed by an edge detector. A strobe change clears the idle count at the third rising edge after it. With power-down armed, `pd_active` rises at the rising edge where the count reaches 15 with no further change, which is the 18th edge after the strobe change.
- R5: A transition in either direction restarts the idle count. If `pd_active` is high, it falls at the edge where the count restarts, which is the third rising edge after the strobe change.
- R6: The idle count stops at 15 and does not wrap. While the strobe stays idle and power-down is armed, `pd_active` stays high.
- R7: `slow_mode` equals bit 3 of register 0. A value of 1 selects the low-power, slower mode.
- R8: `ctl_out[i] = ctl_in[i] & ~mask[i]`. Bit 0 of the mask is register 0 bit 4, bit 1 is register 0 bit 5, and bits 2..6 are register 2 bits 2..6.
- R9: While `pd_active` is high, `ctl_out` is all zeros.
- R10: If the strobe changes less often than once every 15 input-clock cycles, the block falls back into power-down between strobes, once per strobe interval.
- R11: Clearing bit 1 of register 0 while in power-down drops `pd_active` at the next rising edge after the register update. The idle count keeps running while power-down is disarmed, so arming after a long idle spell enters power-down at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Free-running input clock, time base for the idle count |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_in | input | 1 | Address strobe / latch enable from the bus, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = register 0, 1 = register 2 |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 = register 0, 1 = register 2 |
| rd_data | output | 8 | Combinational read data |
| ctl_in | input | 7 | Raw microcontroller control inputs |
| ctl_out | output | 7 | Control inputs after masking and power-down gating |
| pd_active | output | 1 | Power-down state |
| pd_enable | output | 1 | Automatic power-down armed |
| slow_mode | output | 1 | Low-power (non-turbo) logic select |

## Verification
The bench times entry and exit down to the exact edge. A synchronizer that is one stage short or long, or a count that is off by one, moves `pd_active` by a cycle and is caught. It keeps the strobe idle well past the threshold: a wrapping counter would drop out of power-down at the 16th cycle. It exercises both fast and slow strobe rates. Fast strobes must never reach power-down, and slow strobes must re-enter it every interval, which catches a block that only reacts to one edge polarity. It also disarms power-down while in power-down and re-arms it after a long idle spell. A design that gated the counter with the enable, or failed to drop power-down immediately, would show up there. Mask bit order is checked with an asymmetric pattern, so swapped or shifted mask bits are visible.

// File: rtl/idle_pd_pkg.sv
package idle_pd_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_ARM    = 1;
  localparam int BIT_SLOW   = 3;
  localparam int R0_MASK_LO = 4;
  localparam int R0_MASK_N  = 2;
  localparam int R2_MASK_LO = 2;
  localparam int R2_MASK_N  = 5;
  localparam int CTL_N      = R0_MASK_N + R2_MASK_N;

  // next idle count: restart on activity, otherwise count up and hold at limit
  function automatic int unsigned idle_next(int unsigned cnt, logic restart,
                                            int unsigned limit);
    if (restart) return 0;
    if (cnt >= limit) return limit;
    return cnt + 1;
  endfunction

  // one gated control bit
  function automatic logic gate_bit(logic raw, logic blk, logic pd);
    return raw & ~blk & ~pd;
  endfunction
endpackage

// File: rtl/pd_regs.sv
module pd_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] r0_q,
  output logic [W-1:0] r2_q
);
  localparam int NREG = 2;
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= '0;
      else if (wr_en && (wr_sel == 1'(g))) regs[g] <= wr_data;
    end
  end

  assign r0_q    = regs[0];
  assign r2_q    = regs[1];
  assign rd_data = rd_sel ? regs[1] : regs[0];

  assert_wr0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (r0_q == $past(wr_data)));
  assert_wr2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (r2_q == $past(wr_data)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(r0_q) && $stable(r2_q)));
endmodule

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic activity
);
  // sh[STAGES-1:0] is the synchronizer, sh[STAGES] the previous settled value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], strobe_async};
  end

  assign activity = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/idle_pd_fsm.sv
module idle_pd_fsm #(
  parameter int THR = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic activity,
  output logic pd_q
);
  localparam int CW = $clog2(THR + 1);
  logic [CW-1:0] idle_cnt;
  logic [CW-1:0] idle_cnt_nxt;
  logic          reached;

  assign idle_cnt_nxt = CW'(idle_pd_pkg::idle_next(32'(idle_cnt), activity, 32'(THR)));
  assign reached      = (idle_cnt_nxt == CW'(THR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      pd_q     <= 1'b0;
    end else begin
      idle_cnt <= idle_cnt_nxt;
      pd_q     <= arm & ~activity & reached;
    end
  end

  assert_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !pd_q);
  assert_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !activity && idle_cnt >= CW'(THR - 1)) |=> pd_q);
  assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> (!pd_q && idle_cnt == '0));
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt == CW'(THR) && !activity) |=> (idle_cnt == CW'(THR)));
endmodule

// File: rtl/ctl_gate.sv
module ctl_gate #(
  parameter int N = 7
) (
  input  logic [N-1:0] raw,
  input  logic [N-1:0] blk,
  input  logic         pd,
  output logic [N-1:0] gated
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign gated[i] = idle_pd_pkg::gate_bit(raw[i], blk[i], pd);
  end
endmodule

// File: rtl/idle_pd_ctrl.sv
module idle_pd_ctrl #(
  parameter int IDLE_CYCLES = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic       strobe_in,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  input  logic [6:0] ctl_in,
  output logic [6:0] ctl_out,
  output logic       pd_active,
  output logic       pd_enable,
  output logic       slow_mode
);
  import idle_pd_pkg::*;

  logic [REG_W-1:0] r0_q, r2_q;
  logic [CTL_N-1:0] blk_mask;
  logic             activity;
  logic             pd_q;

  pd_regs #(.W(REG_W)) u_regs (
    .clk(clk_in), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .r0_q(r0_q), .r2_q(r2_q)
  );

  strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk_in), .rst_n(rst_n), .strobe_async(strobe_in), .activity(activity)
  );

  idle_pd_fsm #(.THR(IDLE_CYCLES)) u_fsm (
    .clk(clk_in), .rst_n(rst_n), .arm(r0_q[BIT_ARM]), .activity(activity),
    .pd_q(pd_q)
  );

  assign blk_mask = {r2_q[R2_MASK_LO +: R2_MASK_N], r0_q[R0_MASK_LO +: R0_MASK_N]};

  ctl_gate #(.N(CTL_N)) u_gate (
    .raw(ctl_in), .blk(blk_mask), .pd(pd_q), .gated(ctl_out)
  );

  assign pd_active = pd_q;
  assign pd_enable = r0_q[BIT_ARM];
  assign slow_mode = r0_q[BIT_SLOW];

  assert_pd_quiet_R9: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(pd_active) |-> (ctl_out == '0));
endmodule

// File: tb/sim_idle_pd_ctrl.sv
module sim_idle_pd_ctrl;
  logic       clk_in = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_in = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic [6:0] ctl_in = 7'h00;
  logic [6:0] ctl_out;
  logic       pd_active, pd_enable, slow_mode;

  int n_cmp = 0;
  int n_bad = 0;

  idle_pd_ctrl u0 (
    .clk_in(clk_in), .rst_n(rst_n), .strobe_in(strobe_in), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .ctl_in(ctl_in), .ctl_out(ctl_out), .pd_active(pd_active),
    .pd_enable(pd_enable), .slow_mode(slow_mode)
  );

  always #4 clk_in = ~clk_in;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: strobe history queue, integer idle count
  bit strobe_hist[$];
  int m_idle = 0;
  int m_pd = 0;
  int m_r0 = 0;
  int m_r2 = 0;
  int pd_rises = 0;
  int pd_cycles = 0;
  int prev_pd = 0;

  function automatic int exp_ctl(int raw);
    int mask;
    mask = ((m_r0 >> 4) & 3) | (((m_r2 >> 2) & 31) << 2);
    if (m_pd != 0) return 0;
    return raw & ~mask & 127;
  endfunction

  always @(posedge clk_in) begin
    int settled_new, settled_old, act, armed;
    if (!rst_n) begin
      strobe_hist = '{0, 0, 0};
      m_idle = 0; m_pd = 0; m_r0 = 0; m_r2 = 0;
    end else begin
      // hist[2] settled previous, hist[1] settled current
      settled_old = strobe_hist[2];
      settled_new = strobe_hist[1];
      act   = (settled_old != settled_new) ? 1 : 0;
      armed = (m_r0 >> 1) & 1;
      m_idle = act ? 0 : ((m_idle >= 15) ? 15 : m_idle + 1);
      m_pd   = (armed && !act && m_idle == 15) ? 1 : 0;
      strobe_hist.push_front(strobe_in);
      void'(strobe_hist.pop_back());
      if (wr_en) begin
        if (wr_sel) m_r2 = wr_data; else m_r0 = wr_data;
      end
    end
    #3;
    chk("R4/R5 pd_active", pd_active, m_pd);
    chk("R2 rd_data", rd_data, rd_sel ? m_r2 : m_r0);
    chk("R3 pd_enable", pd_enable, (m_r0 >> 1) & 1);
    chk("R7 slow_mode", slow_mode, (m_r0 >> 3) & 1);
    chk("R8/R9 ctl_out", ctl_out, exp_ctl(ctl_in));
    if (pd_active && !prev_pd) pd_rises++;
    if (pd_active) pd_cycles++;
    prev_pd = pd_active;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_in);
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk_in);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk_in);
    wr_en = 1'b0;
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r0, p0;
    tick(3);
    // R1: reset values
    chk("R1 reg0", rd_data, 0);
    rd_sel = 1'b1; tick(1);
    chk("R1 reg2", rd_data, 0);
    chk("R1 pd_active", pd_active, 0);
    rst_n = 1'b1;
    tick(2);

    // R2 / R8: mask mapping with an asymmetric pattern
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h14);
    rd_sel = 1'b0; tick(1);
    chk("R2 read reg0", rd_data, 8'h10);
    rd_sel = 1'b1; tick(1);
    chk("R2 read reg2", rd_data, 8'h14);
    ctl_in = 7'h7F; tick(1);
    chk("R8 mask order", ctl_out, 7'h6A);
    wr(1'b0, 8'h30); wr(1'b1, 8'h7C); tick(1);
    chk("R8 all masked", ctl_out, 0);
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    ctl_in = 7'h55; tick(1);
    chk("R8 none masked", ctl_out, 7'h55);

    // R7: turbo off
    wr(1'b0, 8'h08); tick(1);
    chk("R7 slow_mode set", slow_mode, 1);

    // R3: disarmed, long idle never powers down
    tick(40);
    chk("R3 no pd when disarmed", pd_active, 0);

    // R11: arming after long idle enters at the next edge
    wr(1'b0, 8'h0A);
    chk("R11 not yet", pd_active, 0);
    tick(1);
    chk("R11 enter after arm", pd_active, 1);
    chk("R9 outputs quiet", ctl_out, 0);

    // R5: wake timing
    strobe_in = 1'b1;
    tick(2);
    chk("R5 still down", pd_active, 1);
    tick(1);
    chk("R5 woke", pd_active, 0);

    // R4: entry timing, 18 edges after the change
    tick(14);
    chk("R4 before threshold", pd_active, 0);
    tick(1);
    chk("R4 at threshold", pd_active, 1);

    // R6: stays down without wrap
    tick(40);
    chk("R6 stays down", pd_active, 1);

    // R5: fast strobe never reaches power-down (falling edge included)
    strobe_in = 1'b0; tick(6);
    r0 = pd_rises; p0 = pd_cycles;
    for (int k = 0; k < 12; k++) begin
      strobe_in = ~strobe_in;
      tick(5);
    end
    chk("R5 fast strobe rises", pd_rises - r0, 0);
    chk("R5 fast strobe cycles", pd_cycles - p0, 0);

    // R10: slow strobe re-enters every interval
    r0 = pd_rises;
    for (int k = 0; k < 4; k++) begin
      strobe_in = ~strobe_in;
      tick(25);
    end
    chk("R10 repeated entries", pd_rises - r0, 4);

    // R11: disarm while down
    chk("R11 precondition", pd_active, 1);
    wr(1'b0, 8'h08);
    chk("R11 still down", pd_active, 1);
    tick(1);
    chk("R11 exit on disarm", pd_active, 0);
    tick(20);
    chk("R3 stays up disarmed", pd_active, 0);

    tick(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule